// File: doc/BRIEF.md
# Priority-Threshold Interrupt Request Controller

This block gathers interrupt requests for a set of numbered vectors (256 by default) into a pending register that holds one bit per vector. It offers one vector at a time to the processor. That vector is the highest-numbered pending vector whose priority class is strictly above a 4-bit threshold that software programs. The priority class of a vector is its top four number bits, which are bits 7:4 for 256 vectors. A request that the threshold blocks is not lost. It stays pending until the threshold drops below its class.

The block offers a vector through a valid/ready pair. `irq_valid` with `irq_vector` is the offer, and `irq_ready` is the processor's acknowledge. A transfer happens on a clock edge where both are high. That transfer clears the pending bit of the offered vector, and `irq_valid` drops for the next cycle. The processor may hold `irq_ready` high for as long as it likes. While `irq_valid` is low, `irq_ready` has no effect.

The offer is not held stable while it waits. If a higher-numbered request arrives, or the threshold changes, the offered vector can change or be withdrawn one cycle later. An acknowledge always applies to the vector shown in the cycle it is given. The threshold is written through a plain write-enable port, and its current value can be read back.

Top module: `pirq_ctrl`

## Requirements
- R1: Reset (active-low `rst_n`) clears every pending bit and sets the threshold to 0. After reset `irq_valid` is 0, and no vector is offered until a new request arrives.
- R2: A request sets that vector's pending bit. Requests that repeat over several cycles, or that arrive while the bit is already set, merge into one pending interrupt, which a single acknowledge removes.
- R3: When `thr_wr_en` is high at a clock edge, the threshold takes `thr_wr_data`. `cur_thr` shows the new value straight after that edge.
- R4: A pending vector is offered only if its class (number bits 7:4) is strictly greater than the threshold. Threshold 15 therefore blocks everything. Threshold 0 admits classes 1 to 15. Vectors 0x00 to 0x0F (class 0) are never offered.
- R5: A blocked vector stays pending for an unlimited time and is offered once the threshold is lowered below its class.
- R6: When several eligible vectors are pending, the one with the highest number is offered.
- R7: A transfer (`irq_valid` and `irq_ready` both high at an edge) clears the pending bit of the offered vector, and `irq_valid` is 0 in the following cycle.
- R8: If a new request for the offered vector arrives in the same cycle as its acknowledge, the request wins. The bit stays set, and the vector is offered again after the one-cycle gap.
- R9: `irq_valid` and `irq_vector` are registered. They reflect a change of the pending bits or of the threshold one clock edge after the edge that made the change.
- R10: `irq_ready` while `irq_valid` is 0 changes no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 256 | One request line per vector, sampled each edge |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_data | input | 4 | New threshold value |
| cur_thr | output | 4 | Current threshold |
| irq_valid | output | 1 | A vector is offered |
| irq_vector | output | 8 | Number of the offered vector |
| irq_ready | input | 1 | Acknowledge of the offered vector |

## Verification
Two functions can fall on the same edge: the acknowledge that clears the offered vector's pending bit, and a fresh request that sets that same bit. The bench drives `irq_ready` together with the request line of the offered vector for one cycle. It expects `irq_valid` low in the next cycle and the same vector offered again one cycle after that. A second plain acknowledge must then leave nothing offered. The merge of repeated requests, and the race between a threshold write and the offer, are judged the same way: by what the block offers on the cycles that follow.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned DEF_NUM_VEC = 256;
  localparam int unsigned DEF_CLASS_W = 4;
endpackage

// File: rtl/pirq_pend_bank.sv
module pirq_pend_bank #(
  parameter int unsigned NUM_VEC = pirq_pkg::DEF_NUM_VEC,
  localparam int unsigned IDX_W  = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] req,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic [NUM_VEC-1:0] pend
);
  logic [NUM_VEC-1:0] clr_mask;
  logic [NUM_VEC-1:0] pend_q;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_dec
    assign clr_mask[i] = clr_en && (clr_idx == IDX_W'(i));
  end

  // set dominates clear so a same-cycle request survives its acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= req | (pend_q & ~clr_mask);
  end

  assign pend = pend_q;

  // R2 / R8: every request seen at an edge is pending afterwards
  a_r2_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & $past(req)) == $past(req)));
endmodule

// File: rtl/pirq_select.sv
module pirq_select #(
  parameter int unsigned NUM_VEC = pirq_pkg::DEF_NUM_VEC,
  parameter int unsigned CLASS_W = pirq_pkg::DEF_CLASS_W,
  localparam int unsigned IDX_W  = $clog2(NUM_VEC),
  localparam int unsigned SHIFT  = IDX_W - CLASS_W
) (
  input  logic [NUM_VEC-1:0] pend,
  input  logic [CLASS_W-1:0] thr,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  logic [NUM_VEC-1:0] elig;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_elig
    localparam int unsigned CLS = i >> SHIFT;
    assign elig[i] = pend[i] && (CLASS_W'(CLS) > thr);
  end

  // ascending scan: the last eligible index seen is the highest
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < NUM_VEC; k++) begin
      if (elig[k]) begin
        hit = 1'b1;
        idx = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl #(
  parameter int unsigned NUM_VEC = pirq_pkg::DEF_NUM_VEC,
  parameter int unsigned CLASS_W = pirq_pkg::DEF_CLASS_W,
  localparam int unsigned IDX_W  = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic               thr_wr_en,
  input  logic [CLASS_W-1:0] thr_wr_data,
  output logic [CLASS_W-1:0] cur_thr,
  output logic               irq_valid,
  output logic [IDX_W-1:0]   irq_vector,
  input  logic               irq_ready
);
  logic [CLASS_W-1:0] thr_q;
  logic [NUM_VEC-1:0] pend;
  logic               sel_hit;
  logic [IDX_W-1:0]   sel_idx;
  logic               valid_q;
  logic [IDX_W-1:0]   vec_q;
  logic               xfer;

  assign xfer = valid_q && irq_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         thr_q <= '0;
    else if (thr_wr_en) thr_q <= thr_wr_data;
  end

  pirq_pend_bank #(.NUM_VEC(NUM_VEC)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (irq_req),
    .clr_en  (xfer),
    .clr_idx (vec_q),
    .pend    (pend)
  );

  pirq_select #(.NUM_VEC(NUM_VEC), .CLASS_W(CLASS_W)) u_sel (
    .pend (pend),
    .thr  (thr_q),
    .hit  (sel_hit),
    .idx  (sel_idx)
  );

  // a taken offer is withdrawn for one cycle so it cannot be taken twice
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      valid_q <= xfer ? 1'b0 : sel_hit;
      vec_q   <= sel_idx;
    end
  end

  assign cur_thr    = thr_q;
  assign irq_valid  = valid_q;
  assign irq_vector = vec_q;

  // R4: an offered vector's class beat the threshold that selected it
  a_r4_class_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector[IDX_W-1 -: CLASS_W] > $past(thr_q)));

  // R4: top threshold leaves nothing offered on the next cycle
  a_r4_full_block: assert property (@(posedge clk) disable iff (!rst_n)
    (&thr_q) |=> !irq_valid);

  // R5: an offered vector is always still pending
  a_r5_offer_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> pend[irq_vector]);

  // R7: a transfer without a racing request clears the bit
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && !irq_req[irq_vector]) |=> !pend[$past(irq_vector)]);

  // R7: a transfer drops the offer for one cycle
  a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> !irq_valid);

  // R10: acknowledge without an offer leaves pending bits alone
  a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && irq_ready) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: tb/pirq_ctrl_tb.sv
module pirq_ctrl_tb;
  localparam int NV = 256;
  localparam int NROW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NV-1:0] irq_req = '0;
  logic          thr_wr_en = 1'b0;
  logic [3:0]    thr_wr_data = '0;
  logic [3:0]    cur_thr;
  logic          irq_valid;
  logic [7:0]    irq_vector;
  logic          irq_ready = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pirq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data), .cur_thr(cur_thr),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_ready(irq_ready)
  );

  // row: {req_en, req_idx[8], thr_we, thr_val[4], ack, exp_valid, exp_vec[8]}
  localparam logic [23:0] TBL [NROW] = '{
    {1'b1, 8'h05, 1'b0, 4'd0,  1'b0, 1'b0, 8'h00}, // R4 class 0 never offered
    {1'b1, 8'h20, 1'b0, 4'd0,  1'b0, 1'b1, 8'h20}, // R2
    {1'b1, 8'h90, 1'b0, 4'd0,  1'b0, 1'b1, 8'h90}, // R6
    {1'b0, 8'h00, 1'b1, 4'd9,  1'b0, 1'b0, 8'h00}, // R4 equal class blocked
    {1'b0, 8'h00, 1'b1, 4'd8,  1'b0, 1'b1, 8'h90}, // R5
    {1'b0, 8'h00, 1'b0, 4'd0,  1'b1, 1'b0, 8'h00}, // R7 0x20 still blocked
    {1'b0, 8'h00, 1'b1, 4'd1,  1'b0, 1'b1, 8'h20}, // R5
    {1'b1, 8'hFF, 1'b0, 4'd0,  1'b0, 1'b1, 8'hFF}, // R6
    {1'b0, 8'h00, 1'b1, 4'd15, 1'b0, 1'b0, 8'h00}, // R4 threshold 15
    {1'b0, 8'h00, 1'b1, 4'd0,  1'b0, 1'b1, 8'hFF}, // R5
    {1'b0, 8'h00, 1'b0, 4'd0,  1'b1, 1'b1, 8'h20}, // R7
    {1'b0, 8'h00, 1'b0, 4'd0,  1'b1, 1'b0, 8'h00}, // R7 only 0x05 left
    {1'b1, 8'h11, 1'b0, 4'd0,  1'b0, 1'b1, 8'h11}, // R4 class 1 at thr 0
    {1'b0, 8'h00, 1'b1, 4'd15, 1'b0, 1'b0, 8'h00}, // R4
    {1'b0, 8'h00, 1'b0, 4'd0,  1'b1, 1'b0, 8'h00}, // R10 ack with no offer
    {1'b0, 8'h00, 1'b1, 4'd0,  1'b0, 1'b1, 8'h11}  // R10 0x11 survived
  };

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_in();
    irq_req = '0; thr_wr_en = 1'b0; irq_ready = 1'b0;
  endtask

  task automatic chk(input string req, input logic ev, input logic [7:0] evec);
    checks++;
    if (irq_valid !== ev || (ev && irq_vector !== evec)) begin
      failures++;
      $display("FAIL %s valid=%0b vec=%02h expected valid=%0b vec=%02h",
               req, irq_valid, irq_vector, ev, evec);
    end
  endtask

  task automatic chk_thr(input string req, input logic [3:0] e);
    checks++;
    if (cur_thr !== e) begin
      failures++;
      $display("FAIL %s cur_thr=%0d expected %0d", req, cur_thr, e);
    end
  endtask

  initial begin
    repeat (3) cyc();
    chk("R1", 1'b0, 8'h00);
    chk_thr("R1", 4'd0);
    rst_n = 1'b1;
    cyc();

    for (int r = 0; r < NROW; r++) begin
      logic [23:0] row;
      row = TBL[r];
      idle_in();
      if (row[23]) irq_req[row[22:15]] = 1'b1;
      thr_wr_en   = row[14];
      thr_wr_data = row[13:10];
      irq_ready   = row[9];
      cyc();
      idle_in();
      cyc();
      chk($sformatf("table row %0d", r), row[8], row[7:0]);
    end

    // R8: request and acknowledge of the offered vector 0x11 together
    irq_ready = 1'b1; irq_req[8'h11] = 1'b1;
    cyc(); idle_in();
    chk("R8 gap", 1'b0, 8'h00);
    cyc();
    chk("R8 reoffer", 1'b1, 8'h11);
    irq_ready = 1'b1;
    cyc(); idle_in(); cyc();
    chk("R8 then cleared", 1'b0, 8'h00);

    // R9: one-cycle latency from request to offer
    irq_req[8'h40] = 1'b1;
    cyc(); idle_in();
    chk("R9 not yet", 1'b0, 8'h00);
    cyc();
    chk("R9 offered", 1'b1, 8'h40);

    // R2: repeated requests merge, one acknowledge removes them
    irq_req[8'h40] = 1'b1; cyc(); cyc(); idle_in(); cyc();
    irq_ready = 1'b1; cyc(); idle_in(); cyc();
    chk("R2 merged", 1'b0, 8'h00);

    // R6: several requests in one cycle
    irq_req[8'h33] = 1'b1; irq_req[8'h7A] = 1'b1; irq_req[8'h71] = 1'b1;
    cyc(); idle_in(); cyc();
    chk("R6 highest", 1'b1, 8'h7A);

    // R3 / R4 boundary: class equal to threshold is blocked
    thr_wr_en = 1'b1; thr_wr_data = 4'd7;
    cyc(); idle_in();
    chk_thr("R3 readback", 4'd7);
    cyc();
    chk("R4 equal blocked", 1'b0, 8'h00);
    thr_wr_en = 1'b1; thr_wr_data = 4'd6;
    cyc(); idle_in(); cyc();
    chk("R4 just above", 1'b1, 8'h7A);

    // R1: reset mid-operation clears pending and threshold
    rst_n = 1'b0; cyc(); cyc();
    rst_n = 1'b1; cyc(); cyc();
    chk("R1 pending cleared", 1'b0, 8'h00);
    chk_thr("R1 threshold cleared", 4'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule